// File: doc/BRIEF.md
# PHY Link Mode Resolver

This sequencer brings an Ethernet PHY out of reset and works out the link speed and duplex that the MAC should run at. It reaches the PHY's clause-22 management registers only through a simple register-access port: it raises a request with a register number, a write flag and write data, and the far side answers with a one-cycle acknowledge that also carries read data. The serial management wire protocol sits behind that port and is not part of this block.

A pulse on `start_i` launches the sequence. The block waits for any reset already in progress to finish, resets the PHY, and then takes one of three paths. If the PHY has auto-negotiation switched off, the block forces 10 Mbit half duplex. If negotiation completes, the block compares the local and partner ability registers with a fixed priority. If negotiation does not complete in time, the block falls back to the forced-mode bits of the control register. A MAC that cannot run at gigabit has a gigabit result downgraded, and the PHY is told to use 100 Mbit or 10 Mbit. One timeout, counted in clock cycles from the start pulse, covers the whole sequence. If the PHY's reset bit is still set when that time runs out, the sequence ends in failure.

States: `ST_IDLE`, `ST_RST_WAIT` (poll reg 0 until the reset bit clears), `ST_RST_SET` (write reg 0 with the reset bit), `ST_RST_POLL` (poll reg 0 again), `ST_FORCE_10` (write 0 to reg 0), `ST_AN_POLL` (poll reg 1 for negotiation complete), `ST_AN_FALLBACK` (read reg 0 after a timeout), `ST_GIG_LOCAL` / `ST_GIG_PEER` (read regs 9 and 10), `ST_GIG_DECIDE`, `ST_BASE_LOCAL` / `ST_BASE_PEER` (read regs 4 and 5), `ST_RESOLVE`, `ST_SPEED_WR` (write the downgrade speed to reg 0), `ST_DONE` and `ST_FAIL`.

Transitions:
- A start pulse in `ST_IDLE`, `ST_DONE` or `ST_FAIL` goes to `ST_RST_WAIT`.
- The reset polls stay put while bit 15 reads 1, and go to `ST_FAIL` if the timeout has expired.
- `ST_RST_POLL` goes to `ST_AN_POLL` when bit 12 reads 1 and to `ST_FORCE_10` when it reads 0.
- `ST_AN_POLL` goes to `ST_GIG_LOCAL` on completion with reg 1 bit 8 set, to `ST_BASE_LOCAL` on completion with bit 8 clear, and to `ST_AN_FALLBACK` on timeout.
- `ST_GIG_DECIDE` goes to `ST_BASE_LOCAL` or to `ST_RESOLVE`.
- `ST_RESOLVE` goes to `ST_SPEED_WR` on a downgrade and to `ST_DONE` otherwise.

Top module: `phy_mode_resolver`

## Requirements
- R1: While `mdio_req_o` is high and `mdio_ack_i` is low, the request stays high and its register number, write flag and write data hold steady. A read completes in the cycle `mdio_ack_i` is high, with `mdio_rdata_i` valid in that same cycle.
- R2: After a start pulse, the block reads reg 0 until bit 15 reads 0. It then writes reg 0 with the value it last read, OR'd with bit 15. It then reads reg 0 again until bit 15 reads 0.
- R3: If the timeout has expired when a reg 0 poll still returns bit 15 set, the block ends with `fail_o`=1 and `done_o`=0, and all three mode flags at 0.
- R4: If the reg 0 value read after reset has bit 12 at 0, the block writes 0 to reg 0, never reads reg 1, and finishes with all three mode flags at 0.
- R5: With bit 12 set, the block polls reg 1 until bit 5 reads 1. The timeout is TIMEOUT_CYCLES clock cycles counted from the start pulse, and it also bounds this poll.
- R6: If the reg 1 poll times out, the block reads reg 0 once. It then sets gigabit to bit 6 AND NOT bit 13, 100 Mbit to bit 13 AND NOT bit 6, and full duplex to bit 8, and writes nothing more.
- R7: When reg 1 bit 8 is set, reg 9 and reg 10 are read. A 1000-full match (reg 9 bit 9 and reg 10 bit 11) gives gigabit full. A 1000-half match (reg 9 bit 8 and reg 10 bit 10) gives gigabit half and takes priority over the full match.
- R8: Reg 4 and reg 5 are read when gigabit was not resolved or the MAC lacks gigabit. The checks run in order, each later one overriding earlier duplex settings: both bit 8 gives 100 Mbit full, both bit 7 gives 100 Mbit half, and both bit 6 sets full duplex.
- R9: If gigabit was resolved while `mac_gbit_i` is 0, gigabit and full duplex are cleared. A final write puts bit 13 = 100 Mbit flag, and no other bit, into reg 0.
- R10: When reg 1 bit 8 is clear, reg 9 and reg 10 are never read, and their contents have no effect on the result.
- R11: `done_o` or `fail_o` and the mode flags hold until the next start pulse. No request is issued while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches the sequence when idle, done or failed |
| mac_gbit_i | input | 1 | The MAC supports gigabit |
| mdio_req_o | output | 1 | Register access request |
| mdio_we_o | output | 1 | 1 = write, 0 = read |
| mdio_reg_o | output | 5 | PHY register number |
| mdio_wdata_o | output | 16 | Write data |
| mdio_ack_i | input | 1 | One-cycle access completion |
| mdio_rdata_i | input | 16 | Read data, valid with the acknowledge |
| link_gbit_o | output | 1 | Resolved 1000 Mbit |
| link_100_o | output | 1 | Resolved 100 Mbit |
| link_full_o | output | 1 | Resolved full duplex |
| done_o | output | 1 | Sequence finished successfully |
| fail_o | output | 1 | Sequence ended on a stuck PHY reset |

## Verification
The bench runs every combination of the gigabit ability bits and of the three 10/100 ability bits on both sides, with and without extended status and gigabit MAC support. This catches the main ordering mistakes: a design that let the 1000-full match win over 1000-half, or let 100-full win over 100-half, would report the wrong duplex. It also catches a 10-full match that failed to set full duplex on top of 100-half. A design that skipped the downgrade would show gigabit on a non-gigabit MAC, or would omit the final speed write. The timeout paths are driven with a PHY whose reset bit never clears and with negotiation that never completes. Under those, a wrong design would hang, fail too early, or read the forced-mode bits with the wrong polarity. The bench also counts register reads, which exposes a design that touches regs 9 and 10 without extended status or polls reg 1 when negotiation is disabled.

// File: rtl/phy_res_pkg.sv
package phy_res_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_WAIT,
        ST_RST_SET,
        ST_RST_POLL,
        ST_FORCE_10,
        ST_AN_POLL,
        ST_AN_FALLBACK,
        ST_GIG_LOCAL,
        ST_GIG_PEER,
        ST_GIG_DECIDE,
        ST_BASE_LOCAL,
        ST_BASE_PEER,
        ST_RESOLVE,
        ST_SPEED_WR,
        ST_DONE,
        ST_FAIL
    } state_t;

    typedef struct packed {
        logic gbit;
        logic fast;
        logic full;
    } mode_t;

    // management register numbers
    localparam logic [4:0] REG_CTRL  = 5'd0;
    localparam logic [4:0] REG_STAT  = 5'd1;
    localparam logic [4:0] REG_ADV   = 5'd4;
    localparam logic [4:0] REG_LPA   = 5'd5;
    localparam logic [4:0] REG_GCTL  = 5'd9;
    localparam logic [4:0] REG_GSTAT = 5'd10;

    // control register bits
    localparam int CTL_RESET  = 15;
    localparam int CTL_SPD_LO = 13;
    localparam int CTL_ANEN   = 12;
    localparam int CTL_DUPLEX = 8;
    localparam int CTL_SPD_HI = 6;

    // status register bits
    localparam int STS_EXT    = 8;
    localparam int STS_ANDONE = 5;

    // ability bits
    localparam int ADV_10F    = 6;
    localparam int ADV_100H   = 7;
    localparam int ADV_100F   = 8;
    localparam int GCTL_1000H = 8;
    localparam int GCTL_1000F = 9;
    localparam int GSTS_1000H = 10;
    localparam int GSTS_1000F = 11;

    // number of 10/100 ability bits kept: {100F, 100H, 10F}
    localparam int BASE_BITS = 3;

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int unsigned LIMIT = 300_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (!exp_q) begin
            if (cnt_q == LAST) exp_q <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = exp_q;

    AST_TIMER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q && !clear_i |=> exp_q); // R5

endmodule

// File: rtl/phy_ability_resolve.sv
module phy_ability_resolve
    import phy_res_pkg::*;
(
    input  logic [1:0]           gig_loc_i,   // {1000F, 1000H}
    input  logic [1:0]           gig_peer_i,  // {1000F, 1000H}
    input  logic [BASE_BITS-1:0] base_loc_i,  // {100F, 100H, 10F}
    input  logic [BASE_BITS-1:0] base_peer_i,
    input  logic                 mac_gbit_i,
    output mode_t                mode_o,
    output logic                 need_base_o,
    output logic                 downgrade_o
);
    logic [1:0]           gig_match;
    logic [BASE_BITS-1:0] base_match;

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_gig
            assign gig_match[gi] = gig_loc_i[gi] & gig_peer_i[gi];
        end
        for (gi = 0; gi < BASE_BITS; gi++) begin : g_base
            assign base_match[gi] = base_loc_i[gi] & base_peer_i[gi];
        end
    endgenerate

    logic gig_any, gig_full, base_fast, base_full;

    always_comb begin
        gig_any   = |gig_match;
        gig_full  = gig_match[1] & ~gig_match[0];            // half match wins
        base_fast = base_match[2] | base_match[1];
        base_full = base_match[0] | (base_match[2] & ~base_match[1]);

        need_base_o = ~gig_any | ~mac_gbit_i;
        downgrade_o = gig_any & ~mac_gbit_i;

        if (!need_base_o) begin
            mode_o = '{gbit: 1'b1, fast: 1'b0, full: gig_full};
        end else if (downgrade_o) begin
            mode_o = '{gbit: 1'b0, fast: base_fast, full: 1'b0};
        end else begin
            mode_o = '{gbit: 1'b0, fast: base_fast, full: base_full};
        end
    end

endmodule

// File: rtl/phy_mode_resolver.sv
module phy_mode_resolver
    import phy_res_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 300_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        mac_gbit_i,
    output logic        mdio_req_o,
    output logic        mdio_we_o,
    output logic [4:0]  mdio_reg_o,
    output logic [15:0] mdio_wdata_o,
    input  logic        mdio_ack_i,
    input  logic [15:0] mdio_rdata_i,
    output logic        link_gbit_o,
    output logic        link_100_o,
    output logic        link_full_o,
    output logic        done_o,
    output logic        fail_o
);
    state_t st_q, st_d;

    logic idle_w, go_w, expired_w, ack_w;
    assign idle_w = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL);
    assign go_w   = idle_w && start_i;
    assign ack_w  = mdio_req_o && mdio_ack_i;

    phy_seq_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (go_w),
        .expired_o (expired_w)
    );

    logic [15:0]          ctl_q;
    logic [1:0]           gig_loc_q, gig_peer_q;
    logic [BASE_BITS-1:0] base_loc_q, base_peer_q;
    mode_t                mode_q, res_mode;
    logic                 need_base, downgrade;

    phy_ability_resolve u_resolve (
        .gig_loc_i   (gig_loc_q),
        .gig_peer_i  (gig_peer_q),
        .base_loc_i  (base_loc_q),
        .base_peer_i (base_peer_q),
        .mac_gbit_i  (mac_gbit_i),
        .mode_o      (res_mode),
        .need_base_o (need_base),
        .downgrade_o (downgrade)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL:
                if (start_i) st_d = ST_RST_WAIT;
            ST_RST_WAIT:
                if (ack_w) begin
                    if (!mdio_rdata_i[CTL_RESET]) st_d = ST_RST_SET;
                    else if (expired_w)           st_d = ST_FAIL;
                end
            ST_RST_SET:
                if (ack_w) st_d = ST_RST_POLL;
            ST_RST_POLL:
                if (ack_w) begin
                    if (!mdio_rdata_i[CTL_RESET])
                        st_d = mdio_rdata_i[CTL_ANEN] ? ST_AN_POLL : ST_FORCE_10;
                    else if (expired_w)
                        st_d = ST_FAIL;
                end
            ST_FORCE_10:
                if (ack_w) st_d = ST_DONE;
            ST_AN_POLL:
                if (ack_w) begin
                    if (mdio_rdata_i[STS_ANDONE])
                        st_d = mdio_rdata_i[STS_EXT] ? ST_GIG_LOCAL : ST_BASE_LOCAL;
                    else if (expired_w)
                        st_d = ST_AN_FALLBACK;
                end
            ST_AN_FALLBACK:
                if (ack_w) st_d = ST_DONE;
            ST_GIG_LOCAL:
                if (ack_w) st_d = ST_GIG_PEER;
            ST_GIG_PEER:
                if (ack_w) st_d = ST_GIG_DECIDE;
            ST_GIG_DECIDE:
                st_d = need_base ? ST_BASE_LOCAL : ST_RESOLVE;
            ST_BASE_LOCAL:
                if (ack_w) st_d = ST_BASE_PEER;
            ST_BASE_PEER:
                if (ack_w) st_d = ST_RESOLVE;
            ST_RESOLVE:
                st_d = downgrade ? ST_SPEED_WR : ST_DONE;
            ST_SPEED_WR:
                if (ack_w) st_d = ST_DONE;
            default:
                st_d = ST_IDLE;
        endcase
    end

    // captured register contents and resolved mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            gig_loc_q   <= '0;
            gig_peer_q  <= '0;
            base_loc_q  <= '0;
            base_peer_q <= '0;
            mode_q      <= '0;
        end else if (go_w) begin
            gig_loc_q   <= '0;
            gig_peer_q  <= '0;
            base_loc_q  <= '0;
            base_peer_q <= '0;
            mode_q      <= '0;
        end else begin
            if (ack_w && st_q == ST_RST_WAIT && !mdio_rdata_i[CTL_RESET])
                ctl_q <= mdio_rdata_i;
            if (ack_w && st_q == ST_AN_FALLBACK)
                mode_q <= '{gbit: mdio_rdata_i[CTL_SPD_HI] & ~mdio_rdata_i[CTL_SPD_LO],
                            fast: mdio_rdata_i[CTL_SPD_LO] & ~mdio_rdata_i[CTL_SPD_HI],
                            full: mdio_rdata_i[CTL_DUPLEX]};
            if (ack_w && st_q == ST_GIG_LOCAL)
                gig_loc_q <= {mdio_rdata_i[GCTL_1000F], mdio_rdata_i[GCTL_1000H]};
            if (ack_w && st_q == ST_GIG_PEER)
                gig_peer_q <= {mdio_rdata_i[GSTS_1000F], mdio_rdata_i[GSTS_1000H]};
            if (ack_w && st_q == ST_BASE_LOCAL)
                base_loc_q <= {mdio_rdata_i[ADV_100F], mdio_rdata_i[ADV_100H], mdio_rdata_i[ADV_10F]};
            if (ack_w && st_q == ST_BASE_PEER)
                base_peer_q <= {mdio_rdata_i[ADV_100F], mdio_rdata_i[ADV_100H], mdio_rdata_i[ADV_10F]};
            if (st_q == ST_RESOLVE)
                mode_q <= res_mode;
        end
    end

    // outputs
    always_comb begin
        mdio_req_o   = 1'b0;
        mdio_we_o    = 1'b0;
        mdio_reg_o   = REG_CTRL;
        mdio_wdata_o = '0;
        unique case (st_q)
            ST_RST_WAIT, ST_RST_POLL, ST_AN_FALLBACK: begin
                mdio_req_o = 1'b1;
            end
            ST_RST_SET: begin
                mdio_req_o   = 1'b1;
                mdio_we_o    = 1'b1;
                mdio_wdata_o = ctl_q | (16'd1 << CTL_RESET);
            end
            ST_FORCE_10: begin
                mdio_req_o = 1'b1;
                mdio_we_o  = 1'b1;
            end
            ST_SPEED_WR: begin
                mdio_req_o   = 1'b1;
                mdio_we_o    = 1'b1;
                mdio_wdata_o = 16'(mode_q.fast) << CTL_SPD_LO;
            end
            ST_AN_POLL:    begin mdio_req_o = 1'b1; mdio_reg_o = REG_STAT;  end
            ST_GIG_LOCAL:  begin mdio_req_o = 1'b1; mdio_reg_o = REG_GCTL;  end
            ST_GIG_PEER:   begin mdio_req_o = 1'b1; mdio_reg_o = REG_GSTAT; end
            ST_BASE_LOCAL: begin mdio_req_o = 1'b1; mdio_reg_o = REG_ADV;   end
            ST_BASE_PEER:  begin mdio_req_o = 1'b1; mdio_reg_o = REG_LPA;   end
            default: ;
        endcase
        done_o      = (st_q == ST_DONE);
        fail_o      = (st_q == ST_FAIL);
        link_gbit_o = mode_q.gbit;
        link_100_o  = mode_q.fast;
        link_full_o = mode_q.full;
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req_o && !mdio_ack_i |=> mdio_req_o && $stable(mdio_reg_o)
            && $stable(mdio_we_o) && $stable(mdio_wdata_o)); // R1
    AST_FAIL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !done_o && !link_gbit_o && !link_100_o && !link_full_o); // R3
    AST_SPEED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(link_gbit_o && link_100_o)); // R7
    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !mdio_req_o); // R11
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(link_gbit_o)
            && $stable(link_100_o) && $stable(link_full_o)); // R11

endmodule

// File: tb/phy_mode_resolver_bench.sv
module phy_mode_resolver_bench;
    localparam int T = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mac_gbit = 1'b0;
    logic        req, we, ack;
    logic [4:0]  rnum;
    logic [15:0] wdata, rdata;
    logic        l_g, l_f, l_d, done, fail;

    always #5 clk = ~clk;

    phy_mode_resolver #(.TIMEOUT_CYCLES(T)) u_phy_mode_resolver (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mac_gbit_i(mac_gbit),
        .mdio_req_o(req), .mdio_we_o(we), .mdio_reg_o(rnum), .mdio_wdata_o(wdata),
        .mdio_ack_i(ack), .mdio_rdata_i(rdata),
        .link_gbit_o(l_g), .link_100_o(l_f), .link_full_o(l_d),
        .done_o(done), .fail_o(fail));

    // PHY model
    logic [15:0] regs [32];
    int rst_left, an_left, n_wr, rd_cnt [32];
    logic [4:0]  last_wr_reg;
    logic [15:0] last_wr_data, first_wr_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= 1'b0;
            if (req && !ack) begin
                ack <= 1'b1;
                if (we) begin
                    n_wr = n_wr + 1;
                    if (n_wr == 1) first_wr_data = wdata;
                    last_wr_reg = rnum;
                    last_wr_data = wdata;
                    if (rnum == 5'd0) begin
                        regs[0] = wdata & 16'h7FFF;
                        if (wdata[15]) rst_left = pre_post;
                    end else regs[rnum] = wdata;
                end else begin
                    rd_cnt[rnum] = rd_cnt[rnum] + 1;
                    if (rnum == 5'd0) begin
                        rdata <= regs[0] | (rst_left > 0 ? 16'h8000 : 16'h0);
                        if (rst_left > 0) rst_left = rst_left - 1;
                    end else if (rnum == 5'd1) begin
                        rdata <= regs[1] | (an_left == 0 ? 16'h0020 : 16'h0);
                        if (an_left > 0) an_left = an_left - 1;
                    end else rdata <= regs[rnum];
                end
            end
        end
    end

    int pre_post;
    int n_chk = 0, n_fail = 0, cyc = 0, elapsed;

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic setup(input logic [15:0] ctl, stat, r9, r10, r4, r5,
                         input int pre, post, an);
        for (int i = 0; i < 32; i++) begin regs[i] = '0; rd_cnt[i] = 0; end
        regs[0] = ctl; regs[1] = stat; regs[9] = r9; regs[10] = r10;
        regs[4] = r4; regs[5] = r5;
        rst_left = pre; pre_post = post; an_left = an;
        n_wr = 0; last_wr_reg = '0; last_wr_data = '0; first_wr_data = '0;
    endtask

    task automatic run();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        elapsed = 1;
        while (!done && !fail && elapsed < 4 * T) begin
            @(negedge clk); elapsed++;
        end
    endtask

    function automatic logic [2:0] expect_mode(input bit ext, mac,
        input logic [15:0] r9, r10, r4, r5);
        bit gb = 0, sp = 0, fd = 0;
        if (ext) begin
            if (r9[9] && r10[11]) begin gb = 1; fd = 1; end
            if (r9[8] && r10[10]) begin gb = 1; fd = 0; end
        end
        if (!gb || !mac) begin
            if (r4[8] && r5[8]) begin sp = 1; fd = 1; end
            if (r4[7] && r5[7]) begin sp = 1; fd = 0; end
            if (r4[6] && r5[6]) fd = 1;
            if (gb && !mac) begin gb = 0; fd = 0; end
        end
        return {gb, sp, fd};
    endfunction

    initial begin
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        setup(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check({req, done, fail, l_g, l_f, l_d} == 6'b0, "R11 reset", {req, done, fail, l_g, l_f, l_d}, 0);

        // R2: reset handshake, 3 polls before, 2 after
        mac_gbit = 1'b1;
        setup(16'h1140, 16'h0000, 16'h0, 16'h0, 16'h0101, 16'h0100, 3, 2, 0);
        run();
        check(first_wr_data == 16'h9140, "R2 reset write", first_wr_data, 16'h9140);
        check(rd_cnt[0] == 7, "R2 reg0 polls", rd_cnt[0], 7);
        check(done && {l_g, l_f, l_d} == 3'b011, "R8 100F", {done, l_g, l_f, l_d}, 4'b1011);

        // R11: hold after done
        repeat (10) @(negedge clk);
        check(done && !req && {l_g, l_f, l_d} == 3'b011, "R11 hold", {done, req, l_g, l_f, l_d}, 5'b10011);

        // R4: autonegotiation disabled
        setup(16'h2140, 16'h0120, 16'h0300, 16'h0C00, 16'h01C0, 16'h01C0, 0, 1, 0);
        run();
        check(done && n_wr == 2 && last_wr_reg == 0 && last_wr_data == 0, "R4 write0",
              {n_wr[3:0], last_wr_data}, 20'h20000);
        check({l_g, l_f, l_d} == 3'b000 && rd_cnt[1] == 0, "R4 mode", {l_g, l_f, l_d, rd_cnt[1][3:0]}, 0);

        // R5: negotiation completes after 5 incomplete polls
        setup(16'h1000, 16'h0000, 16'h0, 16'h0, 16'h0040, 16'h0040, 0, 0, 5);
        run();
        check(done && rd_cnt[1] == 6 && {l_g, l_f, l_d} == 3'b001, "R5 poll",
              {done, rd_cnt[1][3:0], l_g, l_f, l_d}, {1'b1, 4'd6, 3'b001});

        // R6: timeout fallback from reg 0 forced-mode bits
        for (int k = 0; k < 8; k++) begin
            logic [15:0] c;
            logic [2:0] e;
            c = 16'h1000 | (k[0] ? 16'h0040 : 0) | (k[1] ? 16'h2000 : 0) | (k[2] ? 16'h0100 : 0);
            e = {k[0] & ~k[1], k[1] & ~k[0], k[2]};
            setup(c, 16'h0100, 16'h0300, 16'h0C00, 16'h01C0, 16'h01C0, 0, 0, 1000000);
            run();
            check(done && {l_g, l_f, l_d} == e && n_wr == 1 && elapsed >= T, "R6 fallback",
                  {done, l_g, l_f, l_d}, {1'b1, e});
        end

        // R3: reset stuck before and after the reset write
        setup(16'h1000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1000000, 0, 0);
        run();
        check(fail && !done && {l_g, l_f, l_d} == 0 && elapsed >= T && elapsed <= T + 8,
              "R3 stuck pre", elapsed, T);
        setup(16'h1000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 1000000, 0);
        run();
        check(fail && !done && n_wr == 1 && elapsed >= T && elapsed <= T + 8,
              "R3 stuck post", elapsed, T);

        // sweeps: R7 R8 R9 R10
        for (int ext = 0; ext < 2; ext++)
            for (int mac = 0; mac < 2; mac++)
                for (int gi = 0; gi < 16; gi++) begin
                    if (ext == 0 && gi != 15) continue;
                    for (int li = 0; li < 64; li++) begin
                        logic [15:0] r9, r10, r4, r5;
                        logic [2:0] e;
                        bit dg;
                        r9  = 16'(gi & 3) << 8;
                        r10 = 16'((gi >> 2) & 3) << 10;
                        r4  = (16'(li & 7) << 6) | 16'h0021;
                        r5  = 16'((li >> 3) & 7) << 6;
                        mac_gbit = mac[0];
                        setup(16'h1000, ext ? 16'h0100 : 16'h0000, r9, r10, r4, r5, 0, 1, 0);
                        run();
                        e = expect_mode(ext[0], mac[0], r9, r10, r4, r5);
                        check(done && {l_g, l_f, l_d} == e, "R7/R8 mode",
                              {done, l_g, l_f, l_d}, {1'b1, e});
                        dg = ext && ((r9[9] && r10[11]) || (r9[8] && r10[10])) && !mac;
                        if (dg)
                            check(n_wr == 2 && last_wr_reg == 0 && last_wr_data == (16'(e[1]) << 13),
                                  "R9 speed write", last_wr_data, 16'(e[1]) << 13);
                        else
                            check(n_wr == 1, "R9 no extra write", n_wr, 1);
                        if (!ext)
                            check(rd_cnt[9] == 0 && rd_cnt[10] == 0, "R10 no gig read",
                                  rd_cnt[9] + rd_cnt[10], 0);
                    end
                end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule